// File: doc/BRIEF.md
# Virtual Channel Input Allocator

This block sits at one input port of a packet router and binds each arriving packet to one of several virtual channels for its whole lifetime. Flits come in over a valid/acknowledge handshake. Each flit carries a data word and two framing bits: one marks the header flit and one marks the last flit, so packets can be any length from one flit up.

When a header arrives and no packet is open, the block picks a channel. The channel must be enabled by an external mask and must not already be locked. The block locks that channel and writes the header into the channel's FIFO. Every following flit of the packet goes into the same FIFO until the last flit has been accepted.

The output side sees each FIFO's head flit and a ready bit for it, and it pops flits with per-channel read strobes. A channel's lock is released when the flit carrying the end-of-packet mark is popped from its FIFO. Only then can the channel be given to a new packet.

Top module: `vc_input_alloc`

## Requirements
- R1: After reset every lock bit and every FIFO ready bit is 0, and `in_ack_o` is 0 while `in_val_i` is 0.
- R2: When no packet is open, a flit with the begin mark is accepted only if some channel is both enabled and unlocked. In that case the lowest-index such channel receives it, and its lock bit is 1 from the next cycle.
- R3: A channel's FIFO returns its flits in arrival order. The head flit is presented as {begin bit, end bit, data}, with the begin bit at position DATA_W+1 and the end bit at position DATA_W. The ready bit is 1 exactly while the FIFO is non-empty. A read strobe with ready high pops one flit.
- R4: Flits after the header go to the channel locked by that header, whatever the enable mask shows.
- R5: When no packet is open and no channel is both enabled and unlocked, a header flit is not acknowledged.
- R6: While a packet is open and its channel's FIFO holds FIFO_DEPTH flits, the flit on the link is not acknowledged.
- R7: A lock bit falls at the clock edge that pops the flit carrying the end mark, and a channel whose lock is 0 has an empty FIFO.
- R8: A header presented in the same cycle that a channel's release pop occurs is not given that channel.
- R9: A channel whose enable bit is 0 is never chosen for a new packet.
- R10: When no packet is open, a flit without the begin mark is acknowledged and discarded, and it reaches no FIFO.
- R11: A flit carrying both marks forms a one-flit packet. It locks its channel and is released when popped, and the next header may be accepted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | DATA_W | Flit data word |
| in_bop_i | input | 1 | Begin-of-packet mark |
| in_eop_i | input | 1 | End-of-packet mark |
| in_val_i | input | 1 | Flit on the link is valid |
| in_ack_o | output | 1 | Flit accepted this cycle |
| vc_en_i | input | NUM_VC | Channels that may take a new packet |
| vc_lock_o | output | NUM_VC | Per-channel lock bits |
| vc_rok_o | output | NUM_VC | Per-channel head flit ready |
| vc_rd_i | input | NUM_VC | Per-channel pop strobes |
| vc_flit_o | output | NUM_VC*(DATA_W+2) | Head flits, channel i at bits [i*(DATA_W+2) +: DATA_W+2] |

## Verification
The bench builds the block with 8-bit data, four channels and a FIFO depth of four. With a depth that shallow, random packets of up to six flits fill a FIFO well before their tail arrives, so the full-FIFO stall of R6 occurs often. Random enable masks, including an all-zero mask, bring the no-candidate stall and the lowest-index choice among the survivors within reach. Directed sequences target the same-cycle release collision, one-flit packets, and stray flits that arrive with no packet open.

// File: rtl/vcia_pkg.sv
package vcia_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BODY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/vcia_fifo.sv
module vcia_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             rok_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  assign rok_o   = (cnt_q != '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign rdata_o = mem_q[rd_ptr_q];
  assign do_pop  = pop_i & rok_o;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R6

  AST_POP_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_pop && !push_i) |=> !full_o); // R3
endmodule

// File: rtl/vcia_pick.sv
module vcia_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]         req_i,
  output logic [N-1:0]         gnt_o,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 any_o
);
  localparam int IDX_W = $clog2(N);

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/vcia_lock.sv
module vcia_lock #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lock_o
);
  for (genvar g = 0; g < N; g++) begin : g_lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lock_o[g] <= 1'b0;
      else if (set_i[g])  lock_o[g] <= 1'b1;
      else if (clr_i[g])  lock_o[g] <= 1'b0;
    end

    AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_o[g] && !clr_i[g]) |=> lock_o[g]); // R7

    AST_SET_ONLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |-> !lock_o[g]); // R8
  end
endmodule

// File: rtl/vc_input_alloc.sv
module vc_input_alloc #(
  parameter int DATA_W     = 8,
  parameter int NUM_VC     = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DATA_W-1:0]            in_data_i,
  input  logic                         in_bop_i,
  input  logic                         in_eop_i,
  input  logic                         in_val_i,
  output logic                         in_ack_o,
  input  logic [NUM_VC-1:0]            vc_en_i,
  output logic [NUM_VC-1:0]            vc_lock_o,
  output logic [NUM_VC-1:0]            vc_rok_o,
  input  logic [NUM_VC-1:0]            vc_rd_i,
  output logic [NUM_VC*(DATA_W+2)-1:0] vc_flit_o
);
  import vcia_pkg::*;

  localparam int FLIT_W = DATA_W + 2;
  localparam int IDX_W  = $clog2(NUM_VC);
  localparam int EOP_B  = DATA_W;

  rx_state_e          state_q;
  logic [IDX_W-1:0]   cur_q;
  logic [NUM_VC-1:0]  cand, sel_oh, full, push, rel;
  logic [IDX_W-1:0]   sel_idx;
  logic               any_free, hdr_go, body_go, drop_go;
  logic [FLIT_W-1:0]  wflit;
  logic [FLIT_W-1:0]  head [NUM_VC];

  assign cand = vc_en_i & ~vc_lock_o;

  vcia_pick #(.N(NUM_VC)) i_pick (
    .req_i (cand),
    .gnt_o (sel_oh),
    .idx_o (sel_idx),
    .any_o (any_free)
  );

  assign hdr_go  = (state_q == RX_IDLE) & in_val_i & in_bop_i & any_free;
  assign drop_go = (state_q == RX_IDLE) & in_val_i & ~in_bop_i;
  assign body_go = (state_q == RX_BODY) & in_val_i & ~full[cur_q];
  assign in_ack_o = hdr_go | drop_go | body_go;
  assign wflit    = {in_bop_i, in_eop_i, in_data_i};

  for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
    assign push[g] = (hdr_go & sel_oh[g]) | (body_go & (cur_q == IDX_W'(g)));
    // release when the tail leaves the FIFO
    assign rel[g]  = vc_rd_i[g] & vc_rok_o[g] & head[g][EOP_B];

    vcia_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[g]),
      .wdata_i (wflit),
      .pop_i   (vc_rd_i[g]),
      .rdata_o (head[g]),
      .rok_o   (vc_rok_o[g]),
      .full_o  (full[g])
    );

    assign vc_flit_o[g*FLIT_W +: FLIT_W] = head[g];

    AST_FREE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vc_lock_o[g] |-> !vc_rok_o[g]); // R7
  end

  vcia_lock #(.N(NUM_VC)) i_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (push & {NUM_VC{hdr_go}}),
    .clr_i  (rel),
    .lock_o (vc_lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cur_q   <= '0;
    end else if (hdr_go && !in_eop_i) begin
      state_q <= RX_BODY;
      cur_q   <= sel_idx;
    end else if (body_go && in_eop_i) begin
      state_q <= RX_IDLE;
    end
  end

  AST_HDR_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_go |=> ((vc_lock_o & ~$past(vc_lock_o)) != '0)); // R2

  AST_ONE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push)); // R3

  AST_EN_RESPECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_go |-> ((push & vc_en_i & ~vc_lock_o) != '0)); // R9

  AST_BODY_NO_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    body_go |-> !full[cur_q]); // R6
endmodule

// File: tb/test_vc_input_alloc.sv
`timescale 1ns/1ps
module test_vc_input_alloc;
  localparam int DW = 8;
  localparam int NV = 4;
  localparam int DP = 4;
  localparam int FW = DW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_bop = 1'b0, in_eop = 1'b0, in_val = 1'b0;
  logic in_ack;
  logic [NV-1:0] vc_en = '1, vc_rd = '0;
  logic [NV-1:0] vc_lock, vc_rok;
  logic [NV*FW-1:0] vc_flit;

  always #2 clk = ~clk;

  vc_input_alloc #(.DATA_W(DW), .NUM_VC(NV), .FIFO_DEPTH(DP)) i_vc_input_alloc (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_bop_i(in_bop),
    .in_eop_i(in_eop), .in_val_i(in_val), .in_ack_o(in_ack), .vc_en_i(vc_en),
    .vc_lock_o(vc_lock), .vc_rok_o(vc_rok), .vc_rd_i(vc_rd), .vc_flit_o(vc_flit)
  );

  int n_chk = 0, n_bad = 0;
  logic [FW-1:0] mq [NV][DP];
  int  mcnt [NV];
  logic [NV-1:0] mlock = '0;
  bit  mopen = 0;
  int  mcur = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest_free(input logic [NV-1:0] en, input logic [NV-1:0] lk);
    for (int i = 0; i < NV; i++) if (en[i] && !lk[i]) return i;
    return -1;
  endfunction

  // one cycle: inputs applied after negedge, checked, model advanced, edge taken
  task automatic step(input logic v, input logic [FW-1:0] f, input logic [NV-1:0] en,
                      input logic [NV-1:0] rd, output logic acked);
    bit exp_ack;
    int tgt;
    string tag;
    in_val = v; {in_bop, in_eop, in_data} = f; vc_en = en; vc_rd = rd;
    #1;
    tgt = -1;
    if (!mopen) begin
      if (f[FW-1]) begin
        tgt = lowest_free(en, mlock);
        exp_ack = v && (tgt >= 0);
        tag = "R5";
      end else begin
        exp_ack = v;
        tag = "R10";
      end
    end else begin
      exp_ack = v && (mcnt[mcur] < DP);
      tgt = mcur;
      tag = "R6";
    end
    check(in_ack === exp_ack, tag, 32'(in_ack), 32'(exp_ack));
    check(vc_lock === mlock, "R7", 32'(vc_lock), 32'(mlock));
    for (int i = 0; i < NV; i++) begin
      check(vc_rok[i] === (mcnt[i] > 0), "R3", 32'(vc_rok[i]), 32'(mcnt[i] > 0));
      if (mcnt[i] > 0)
        check(vc_flit[i*FW +: FW] === mq[i][0], "R3", 32'(vc_flit[i*FW +: FW]), 32'(mq[i][0]));
    end
    acked = in_ack;
    for (int i = 0; i < NV; i++) begin
      if (rd[i] && mcnt[i] > 0) begin
        if (mq[i][0][DW]) mlock[i] = 1'b0;
        for (int k = 0; k < DP - 1; k++) mq[i][k] = mq[i][k+1];
        mcnt[i]--;
      end
    end
    if (exp_ack && tgt >= 0) begin
      mq[tgt][mcnt[tgt]] = f;
      mcnt[tgt]++;
      if (!mopen) begin
        mlock[tgt] = 1'b1;
        if (!f[DW]) begin mopen = 1; mcur = tgt; end
      end else if (f[DW]) mopen = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [FW-1:0] mk(input bit b, input bit e, input int d);
    return {b, e, DW'(d)};
  endfunction

  task automatic drain();
    logic a;
    for (int i = 0; i < 12; i++) step(1'b0, '0, '1, '1, a);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a;
    logic [FW-1:0] pend;
    bit have, in_pkt;
    int left;
    logic [NV-1:0] en_r;
    for (int i = 0; i < NV; i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(vc_lock === '0, "R1", 32'(vc_lock), 0);
    check(vc_rok === '0, "R1", 32'(vc_rok), 0);
    check(in_ack === 1'b0, "R1", 32'(in_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R2: only channel 2 enabled
    step(1'b1, mk(1, 0, 8'h11), 4'b0100, '0, a);
    check(a === 1'b1, "R2", 32'(a), 1);
    check(vc_lock === 4'b0100, "R9", 32'(vc_lock), 32'b0100);
    // R4: body follows header with mask cleared
    step(1'b1, mk(0, 0, 8'h12), 4'b0000, '0, a);
    step(1'b1, mk(0, 1, 8'h13), 4'b0000, '0, a);
    check(vc_rok === 4'b0100, "R4", 32'(vc_rok), 32'b0100);
    // R7: pop three flits, lock drops after tail pop
    step(1'b0, '0, '1, 4'b0100, a);
    step(1'b0, '0, '1, 4'b0100, a);
    check(vc_lock === 4'b0100, "R7", 32'(vc_lock), 32'b0100);
    step(1'b0, '0, '1, 4'b0100, a);
    check(vc_lock === 4'b0000, "R7", 32'(vc_lock), 0);

    // R11 then R8: one-flit packet on channel 0, header collides with release
    step(1'b1, mk(1, 1, 8'h21), 4'b0001, '0, a);
    check(vc_lock === 4'b0001, "R11", 32'(vc_lock), 1);
    step(1'b1, mk(1, 1, 8'h22), 4'b0001, 4'b0001, a);
    check(a === 1'b0, "R8", 32'(a), 0);
    check(vc_lock === 4'b0000, "R11", 32'(vc_lock), 0);
    step(1'b1, mk(1, 1, 8'h22), 4'b0001, '0, a);
    check(a === 1'b1, "R11", 32'(a), 1);
    drain();

    // R5: nothing enabled
    step(1'b1, mk(1, 0, 8'h31), 4'b0000, '0, a);
    check(a === 1'b0, "R5", 32'(a), 0);
    // R6: fill channel 1
    step(1'b1, mk(1, 0, 8'h41), 4'b0010, '0, a);
    for (int k = 0; k < DP - 1; k++) step(1'b1, mk(0, 0, 8'h42 + k), 4'b0010, '0, a);
    step(1'b1, mk(0, 1, 8'h4f), 4'b0010, '0, a);
    check(a === 1'b0, "R6", 32'(a), 0);
    step(1'b1, mk(0, 1, 8'h4f), 4'b0010, 4'b0010, a);
    step(1'b1, mk(0, 1, 8'h4f), 4'b0010, '0, a);
    check(a === 1'b1, "R6", 32'(a), 1);
    drain();
    // R10: stray flit with no packet open
    step(1'b1, mk(0, 1, 8'h55), '1, '0, a);
    check(a === 1'b1, "R10", 32'(a), 1);
    step(1'b0, '0, '1, '0, a);
    check(vc_rok === '0, "R10", 32'(vc_rok), 0);

    // random traffic
    void'($urandom(32'h5eed));
    have = 0; in_pkt = 0; left = 0; en_r = '1;
    for (int c = 0; c < 4000; c++) begin
      if (c % 40 == 0) en_r = NV'($urandom);
      if (!have) begin
        if (!in_pkt) begin
          if ($urandom % 16 == 0) pend = mk(0, $urandom % 2, $urandom);
          else begin
            left = 1 + $urandom % 6;
            pend = mk(1, left == 1, $urandom);
            in_pkt = (left > 1);
          end
        end else begin
          left--;
          pend = mk(0, left == 1, $urandom);
          if (left == 1) in_pkt = 0;
        end
        have = 1;
      end
      step(($urandom % 10) < 7, pend, en_r,
           ($urandom % 4 == 0) ? '0 : NV'($urandom), a);
      if (a) have = 0;
    end
    drain();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule